// File: doc/BRIEF.md
# UART Receive Character Timeout Detector

This block sits next to a UART receive FIFO. It raises a timeout when received data has waited too long without service. It counts bit-rate ticks in units of one character time. The length of a character time follows the programmed frame: start bit, 5 to 8 data bits, optional parity and one or two stop bits. When four such character times pass with no push into the FIFO and no host read from it, and the FIFO holds at least one character, the timeout becomes pending.

The pending indication is cleared by a host read of the receive buffer. It is also dropped when the FIFO empties or FIFO mode is turned off. It is presented both as a plain flag and as a 4-bit interrupt identification code. That code can be merged into a wider interrupt priority encoder elsewhere. The receiver shifter, the FIFO storage and the baud generator are outside this block.

Top module: `uart_rx_char_timeout`

## Requirements
- R1: One character time is F = 1 + (5 + data_bits_i) + parity_en_i + (stop2_i ? 2 : 1) bit ticks, where data_bits_i 2'b00..2'b11 selects 5..8 data bits.
- R2: With the FIFO enabled and non-empty, timeout_o rises on the clock edge that samples the 4*F-th bit tick counted since the last push or pop, and not earlier.
- R3: A push_i or pop_i pulse restarts the timeout window from zero.
- R4: While fifo_count_i is zero the window is held at zero and timeout_o is low from the next cycle on.
- R5: While fifo_en_i is low the window is held at zero and timeout_o is low from the next cycle on.
- R6: A pop_i pulse clears a pending timeout on the next edge; a push_i pulse does not clear it.
- R7: When pop_i arrives in the same cycle as the expiring tick, the clear wins: timeout_o stays low and a new full 4*F tick window starts.
- R8: iid_o is 4'b1100 while the timeout is pending and 4'b0001 otherwise (bit 0 low means pending, bit 3 marks a FIFO-mode source).
- R9: After reset timeout_o is low and iid_o is 4'b0001.
- R10: Only cycles with bit_tick_i high advance the window; idle cycles between ticks do not count.
- R11: Once pending, timeout_o holds through further ticks until a clear condition of R4, R5 or R6 occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One pulse per serial bit period |
| data_bits_i | input | 2 | Data bit count minus five |
| parity_en_i | input | 1 | Parity bit present in frame |
| stop2_i | input | 1 | Two stop bits when high |
| fifo_en_i | input | 1 | FIFO mode enable |
| fifo_count_i | input | CNT_W | Receive FIFO occupancy |
| push_i | input | 1 | Receiver wrote a character into the FIFO |
| pop_i | input | 1 | Host read of the receive buffer |
| timeout_o | output | 1 | Character timeout pending |
| iid_o | output | 4 | Interrupt identification code |

## Verification
A host read can land in the same cycle as the tick that would complete the fourth character time. This is the expiry/clear collision. The bench provokes it by running exactly 4*F-1 ticks after a push and then driving pop_i together with the final tick. It then requires timeout_o to stay low and a fresh, complete 4*F tick window to pass before the flag rises. It also overlaps a push with an already pending timeout and checks that the flag survives.

// File: rtl/uart_cto_pkg.sv
package uart_cto_pkg;
  localparam int unsigned MAX_FRAME_BITS = 12;
  localparam int unsigned FRAME_W = $clog2(MAX_FRAME_BITS + 1);

  typedef logic [FRAME_W-1:0] frame_len_t;

  localparam logic [3:0] IID_NONE    = 4'b0001;
  localparam logic [3:0] IID_CHAR_TO = 4'b1100;
endpackage

// File: rtl/uart_cto_frame_len.sv
module uart_cto_frame_len
  import uart_cto_pkg::*;
(
  input  logic [1:0] data_bits_i,
  input  logic       parity_en_i,
  input  logic       stop2_i,
  output frame_len_t frame_bits_o
);
  // start + data + parity + stop
  always_comb begin
    frame_bits_o = frame_len_t'(1) + frame_len_t'(5) + frame_len_t'(data_bits_i)
                 + frame_len_t'(parity_en_i) + frame_len_t'(1) + frame_len_t'(stop2_i);
  end
endmodule

// File: rtl/uart_cto_bit_slot.sv
module uart_cto_bit_slot
  import uart_cto_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       tick_i,
  input  frame_len_t frame_bits_i,
  output logic       char_done_o
);
  frame_len_t bit_cnt_q;
  logic       last_slot;

  // >= tolerates a frame shortened mid-count
  assign last_slot   = (bit_cnt_q >= frame_bits_i - frame_len_t'(1));
  assign char_done_o = !restart_i && tick_i && last_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bit_cnt_q <= '0;
    else if (restart_i) bit_cnt_q <= '0;
    else if (tick_i) begin
      if (last_slot) bit_cnt_q <= '0;
      else           bit_cnt_q <= bit_cnt_q + frame_len_t'(1);
    end
  end

  // R3
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (bit_cnt_q == '0));
endmodule

// File: rtl/uart_cto_char_window.sv
module uart_cto_char_window #(
  parameter int unsigned CHARS  = 4,
  localparam int unsigned CHAR_W = $clog2(CHARS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic char_done_i,
  output logic expire_o
);
  logic [CHAR_W-1:0] char_cnt_q;

  assign expire_o = char_done_i && (char_cnt_q == CHAR_W'(CHARS - 1));

  // saturates at CHARS so a pending timeout does not re-fire
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        char_cnt_q <= '0;
    else if (restart_i) char_cnt_q <= '0;
    else if (char_done_i && char_cnt_q != CHAR_W'(CHARS))
      char_cnt_q <= char_cnt_q + CHAR_W'(1);
  end

  // R11
  char_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_cnt_q <= CHAR_W'(CHARS));

  // R3
  char_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (char_cnt_q == '0));
endmodule

// File: rtl/uart_rx_char_timeout.sv
module uart_rx_char_timeout
  import uart_cto_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             stop2_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             timeout_o,
  output logic [3:0]       iid_o
);
  frame_len_t frame_bits;
  logic       active, restart, char_done, expire, timeout_q;

  assign active  = fifo_en_i && (fifo_count_i != '0);
  assign restart = push_i || pop_i || !active;

  uart_cto_frame_len u_frame_len (
    .data_bits_i  (data_bits_i),
    .parity_en_i  (parity_en_i),
    .stop2_i      (stop2_i),
    .frame_bits_o (frame_bits)
  );

  uart_cto_bit_slot u_bit_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart),
    .tick_i       (bit_tick_i),
    .frame_bits_i (frame_bits),
    .char_done_o  (char_done)
  );

  uart_cto_char_window #(.CHARS(CHARS)) u_char_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .char_done_i (char_done),
    .expire_o    (expire)
  );

  // clear beats expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                timeout_q <= 1'b0;
    else if (!active || pop_i)  timeout_q <= 1'b0;
    else if (expire)            timeout_q <= 1'b1;
  end

  assign timeout_o = timeout_q;
  assign iid_o     = timeout_q ? IID_CHAR_TO : IID_NONE;

  // R5
  fifo_off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> !timeout_o);

  // R6
  pop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> !timeout_o);

  // R4
  empty_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_count_i == '0) |=> !timeout_o);

  // R10
  rise_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(bit_tick_i));
endmodule

// File: tb/uart_rx_char_timeout_tb_top.sv
module uart_rx_char_timeout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_tick = 1'b0, parity_en = 1'b0, stop2 = 1'b0, fifo_en = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [1:0] data_bits = 2'b00;
  logic [CNT_W-1:0] fifo_count = '0;
  logic timeout;
  logic [3:0] iid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_char_timeout #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(bit_tick),
    .data_bits_i(data_bits), .parity_en_i(parity_en), .stop2_i(stop2),
    .fifo_en_i(fifo_en), .fifo_count_i(fifo_count),
    .push_i(push), .pop_i(pop), .timeout_o(timeout), .iid_o(iid)
  );

  // {data_bits, parity, stop2, expected frame bits}
  localparam logic [7:0] VEC [6] = '{
    {2'b00, 1'b0, 1'b0, 4'd7},
    {2'b11, 1'b0, 1'b0, 4'd10},
    {2'b11, 1'b1, 1'b1, 4'd12},
    {2'b01, 1'b1, 1'b0, 4'd9},
    {2'b10, 1'b0, 1'b1, 4'd10},
    {2'b00, 1'b1, 1'b1, 4'd9}
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ticks(int n);
    bit_tick = 1'b1;
    repeat (n) step();
    bit_tick = 1'b0;
  endtask

  task automatic do_push();
    push = 1'b1; step(); push = 1'b0;
  endtask

  task automatic drain();
    pop = 1'b1; step(); pop = 1'b0; fifo_count = '0; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int f;
    repeat (3) step();
    // R9 reset state
    check("R9 flag", {3'b0, timeout}, 4'h0);
    check("R9 iid", iid, 4'b0001);
    rst_ni = 1'b1;
    step();
    fifo_en = 1'b1;

    // R1 R2 R8 R6: table walk
    for (int v = 0; v < 6; v++) begin
      {data_bits, parity_en, stop2} = VEC[v][7:4];
      f = int'(VEC[v][3:0]);
      fifo_count = 5'd1;
      do_push();
      ticks(4*f - 1);
      check("R2 early", {3'b0, timeout}, 4'h0);
      ticks(1);
      check("R1 R2 expiry", {3'b0, timeout}, 4'h1);
      check("R8 iid pending", iid, 4'b1100);
      fifo_count = 5'd2;
      do_push();
      check("R6 push keeps", {3'b0, timeout}, 4'h1);
      drain();
      check("R6 pop clears", {3'b0, timeout}, 4'h0);
      check("R8 iid idle", iid, 4'b0001);
    end

    // R10: ticks with idle gaps (8N1, F=10)
    {data_bits, parity_en, stop2} = 4'b1100;
    fifo_count = 5'd1;
    do_push();
    for (int i = 0; i < 39; i++) begin
      ticks(1); step();
    end
    check("R10 gaps early", {3'b0, timeout}, 4'h0);
    ticks(1);
    check("R10 gaps expiry", {3'b0, timeout}, 4'h1);
    // R11: holds through more ticks
    ticks(200);
    check("R11 hold", {3'b0, timeout}, 4'h1);
    drain();

    // R3: pop mid-window restarts
    fifo_count = 5'd3;
    do_push();
    ticks(39);
    pop = 1'b1; step(); pop = 1'b0; fifo_count = 5'd2;
    ticks(39);
    check("R3 restart", {3'b0, timeout}, 4'h0);
    ticks(1);
    check("R3 after full", {3'b0, timeout}, 4'h1);
    drain();

    // R7: pop together with expiring tick
    fifo_count = 5'd3;
    do_push();
    ticks(39);
    pop = 1'b1; bit_tick = 1'b1; step(); pop = 1'b0; bit_tick = 1'b0;
    fifo_count = 5'd2;
    check("R7 clear wins", {3'b0, timeout}, 4'h0);
    ticks(39);
    check("R7 new window", {3'b0, timeout}, 4'h0);
    ticks(1);
    check("R7 new expiry", {3'b0, timeout}, 4'h1);
    drain();

    // R4: empty FIFO never times out
    fifo_count = '0;
    ticks(100);
    check("R4 empty", {3'b0, timeout}, 4'h0);
    // R4: emptying drops pending flag
    fifo_count = 5'd1;
    do_push();
    ticks(40);
    check("R4 pend", {3'b0, timeout}, 4'h1);
    fifo_count = '0; step();
    check("R4 empty clears", {3'b0, timeout}, 4'h0);

    // R5: FIFO mode off
    fifo_count = 5'd1;
    do_push();
    ticks(40);
    check("R5 pend", {3'b0, timeout}, 4'h1);
    fifo_en = 1'b0; step();
    check("R5 off clears", {3'b0, timeout}, 4'h0);
    do_push();
    ticks(100);
    check("R5 off no fire", {3'b0, timeout}, 4'h0);
    check("R5 iid", iid, 4'b0001);

    finish_run();
  end
endmodule